// File: doc/BRIEF.md
# Chroma 4:2:2 to 4:4:4 Formatter and Upsampler

This block takes a single 8-bit colour-difference stream in which red-difference (Cr) and blue-difference (Cb) samples alternate, each component therefore running at half the pixel rate. It first normalises every byte: it converts the number format to two's complement, optionally negates the value, and passes it through a delay trim that moves the chroma by up to two full-rate clocks either way against the luma path.

After normalisation the stream is split into its two components. The block then interpolates each component by two with a linear-phase filter. Even output samples repeat the received pairs. Odd output samples are the rounded mean of two neighbouring pairs. The result is a co-sited Cr/Cb output pair on every full-rate clock enable, with a valid strobe.

All timing follows the full-rate enable `ce`. An input byte is taken only on a cycle with `ce` high, and results leave only on the cycle after such a cycle.

Top module: `chroma_444_upsampler`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `cr_out` and `cb_out` to 0 and empties the pipeline. No output then appears until new pairs arrive.
- R2: With `cfg_offset_bin`=1 the input byte is offset binary and is converted by inverting bit 7. With 0 it is taken as two's complement unchanged. Both codings give identical outputs for the same value.
- R3: With `cfg_negate`=1 the converted value is negated before any further step, and -128 saturates to +127.
- R4: `chroma_is_cr`=1 marks a Cr byte and 0 marks a Cb byte. A pair is a Cr byte followed by a Cb byte. A Cb byte with no Cr byte pending is discarded.
- R5: Even outputs carry the received pairs unchanged and in order. Each output cycle presents Cr and Cb of the same site together.
- R6: The odd output between pair k and pair k+1 is floor((a+b+1)/2) per component, taken over the two-pair signed values.
- R7: With `ce` high every cycle, take the edge at which the first byte (a Cr) is captured as edge 0. The first `out_valid` follows edge 3+d, where d = `cfg_trim` (0..4). Code 2 is the centre, and codes 0 and 4 give -2 and +2 clocks.
- R8: `cfg_trim` codes 5, 6 and 7 behave as code 2.
- R9: `out_valid` is high for one cycle only after an edge where `ce` was high. `cr_out` and `cb_out` hold their values while `out_valid` is low.
- R10: The first output is the original first pair, emitted when the Cr byte of the second pair is taken. No interpolated output appears before two pairs have been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Full-rate sample enable |
| chroma_in | input | 8 | Multiplexed Cr/Cb byte |
| chroma_is_cr | input | 1 | 1 = Cr byte, 0 = Cb byte |
| cfg_offset_bin | input | 1 | 1 = input coded offset binary |
| cfg_negate | input | 1 | 1 = negate chroma |
| cfg_trim | input | 3 | Delay trim code, 2 = centre |
| cr_out | output | 8 | Interpolated Cr, two's complement |
| cb_out | output | 8 | Interpolated Cb, two's complement |
| out_valid | output | 1 | Output pair updated this cycle |

## Verification
The interpolator is driven with a pair sequence that contains the extremes +127 and -128. Some neighbours in it sum to odd values of both signs, so floor rounding can be told apart from truncation toward zero. The same sequence is replayed in offset-binary coding and with negation, which separates bit-7 conversion from negation and exposes a missing saturation at -128. A run with `ce` gaps, and another with a stray leading Cb byte, show that progress follows the enable and that unpaired bytes are dropped. Each of the eight trim codes is run on its own and timed to the first valid output, which tells the five real delays apart from the clamped codes.

// File: rtl/cfmt_pkg.sv
package cfmt_pkg;

  typedef enum logic {
    PH_CB = 1'b0,
    PH_CR = 1'b1
  } phase_e;

endpackage

// File: rtl/cfmt_normalize.sv
module cfmt_normalize #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [DATA_W-1:0] din,
  input  logic              din_is_cr,
  input  logic              offset_bin,
  input  logic              negate,
  output logic [DATA_W-1:0] q_val,
  output logic              q_is_cr,
  output logic              q_vld
);
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] twos_c;
  logic [DATA_W-1:0] signed_c;

  always_comb begin
    twos_c = offset_bin ? (din ^ MSB_MASK) : din;
    if (!negate)                signed_c = twos_c;
    else if (twos_c == MOST_NEG) signed_c = MOST_POS;
    else                        signed_c = (~twos_c) + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_val   <= '0;
      q_is_cr <= 1'b0;
      q_vld   <= 1'b0;
    end else if (ce) begin
      q_val   <= signed_c;
      q_is_cr <= din_is_cr;
      q_vld   <= 1'b1;
    end
  end
endmodule

// File: rtl/cfmt_delay_trim.sv
module cfmt_delay_trim #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAX_TRIM = 2,
  parameter int unsigned CODE_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [CODE_W-1:0] trim_code,
  input  logic [DATA_W-1:0] in_val,
  input  logic              in_is_cr,
  input  logic              in_vld,
  output logic [DATA_W-1:0] out_val,
  output logic              out_is_cr,
  output logic              out_vld
);
  localparam int unsigned DEPTH = 2 * MAX_TRIM;
  localparam int unsigned ENT_W = DATA_W + 1;
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(DEPTH);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(MAX_TRIM);

  generate
    if (DEPTH == 0) begin : g_bypass
      assign out_val   = in_val;
      assign out_is_cr = in_is_cr;
      assign out_vld   = in_vld;
    end else begin : g_line
      logic [ENT_W-1:0]  line_q [DEPTH];
      logic [DEPTH-1:0]  vld_q;
      logic [ENT_W-1:0]  taps   [DEPTH+1];
      logic [DEPTH:0]    tap_vld;
      logic [CODE_W-1:0] sel;

      always_ff @(posedge clk) begin
        if (ce) begin
          line_q[0] <= {in_is_cr, in_val};
          for (int i = 1; i < int'(DEPTH); i++) line_q[i] <= line_q[i-1];
        end
      end

      always_ff @(posedge clk) begin
        if (rst)     vld_q <= '0;
        else if (ce) vld_q <= {vld_q[DEPTH-1:0] << 1} | {{(DEPTH-1){1'b0}}, in_vld};
      end

      always_comb begin
        taps[0]    = {in_is_cr, in_val};
        tap_vld[0] = in_vld;
        for (int i = 1; i <= int'(DEPTH); i++) begin
          taps[i]    = line_q[i-1];
          tap_vld[i] = vld_q[i-1];
        end
        sel = (trim_code > TOP_CODE) ? MID_CODE : trim_code;
      end

      assign {out_is_cr, out_val} = taps[sel];
      assign out_vld              = tap_vld[sel];
    end
  endgenerate
endmodule

// File: rtl/cfmt_interp2x.sv
module cfmt_interp2x #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [DATA_W-1:0] in_val,
  input  logic              in_is_cr,
  input  logic              in_vld,
  output logic [DATA_W-1:0] cr_q,
  output logic [DATA_W-1:0] cb_q,
  output logic              vld_q
);
  import cfmt_pkg::*;

  localparam int unsigned SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] cr_hold;
  logic              cr_pending;
  logic [DATA_W-1:0] prev_cr;
  logic [DATA_W-1:0] prev_cb;
  logic [1:0]        pairs;
  logic [DATA_W-1:0] mid_cr;
  logic [DATA_W-1:0] mid_cb;
  phase_e            ph;

  function automatic logic [DATA_W-1:0] mean_up(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = {a[DATA_W-1], a} + {b[DATA_W-1], b} + SUM_W'(1);
    return s[SUM_W-1:1];
  endfunction

  always_comb begin
    ph     = phase_e'(in_is_cr);
    mid_cr = mean_up(prev_cr, cr_hold);
    mid_cb = mean_up(prev_cb, in_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_hold    <= '0;
      cr_pending <= 1'b0;
      prev_cr    <= '0;
      prev_cb    <= '0;
      pairs      <= 2'd0;
      cr_q       <= '0;
      cb_q       <= '0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (ce && in_vld) begin
        if (ph == PH_CR) begin
          cr_hold    <= in_val;
          cr_pending <= 1'b1;
          if (pairs != 2'd0) begin
            cr_q  <= prev_cr;
            cb_q  <= prev_cb;
            vld_q <= 1'b1;
          end
        end else if (cr_pending) begin
          cr_pending <= 1'b0;
          prev_cr    <= cr_hold;
          prev_cb    <= in_val;
          if (pairs != 2'd2) pairs <= pairs + 2'd1;
          if (pairs != 2'd0) begin
            cr_q  <= mid_cr;
            cb_q  <= mid_cb;
            vld_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/chroma_444_upsampler.sv
module chroma_444_upsampler #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAX_TRIM = 2,
  parameter int unsigned CODE_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [DATA_W-1:0] chroma_in,
  input  logic              chroma_is_cr,
  input  logic              cfg_offset_bin,
  input  logic              cfg_negate,
  input  logic [CODE_W-1:0] cfg_trim,
  output logic [DATA_W-1:0] cr_out,
  output logic [DATA_W-1:0] cb_out,
  output logic              out_valid
);
  logic [DATA_W-1:0] n_val, d_val;
  logic              n_cr, n_vld, d_cr, d_vld;

  cfmt_normalize #(.DATA_W(DATA_W)) norm_i (
    .clk(clk), .rst(rst), .ce(ce),
    .din(chroma_in), .din_is_cr(chroma_is_cr),
    .offset_bin(cfg_offset_bin), .negate(cfg_negate),
    .q_val(n_val), .q_is_cr(n_cr), .q_vld(n_vld)
  );

  cfmt_delay_trim #(.DATA_W(DATA_W), .MAX_TRIM(MAX_TRIM), .CODE_W(CODE_W)) trim_i (
    .clk(clk), .rst(rst), .ce(ce), .trim_code(cfg_trim),
    .in_val(n_val), .in_is_cr(n_cr), .in_vld(n_vld),
    .out_val(d_val), .out_is_cr(d_cr), .out_vld(d_vld)
  );

  cfmt_interp2x #(.DATA_W(DATA_W)) interp_i (
    .clk(clk), .rst(rst), .ce(ce),
    .in_val(d_val), .in_is_cr(d_cr), .in_vld(d_vld),
    .cr_q(cr_out), .cb_q(cb_out), .vld_q(out_valid)
  );
endmodule

// File: rtl/chroma_444_upsampler_chk.sv
module chroma_444_upsampler_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic [DATA_W-1:0] cr_out,
  input logic [DATA_W-1:0] cb_out,
  input logic              out_valid
);
  logic [2:0] ce_seen;

  always_ff @(posedge clk) begin
    if (rst)                       ce_seen <= 3'd0;
    else if (ce && ce_seen != 3'd7) ce_seen <= ce_seen + 3'd1;
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && cr_out == '0 && cb_out == '0));

  // R9
  a_r9_valid_needs_ce: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(ce));

  // R9
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> ($stable(cr_out) && $stable(cb_out)));

  // R10
  a_r10_no_early_output: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ce_seen >= 3'd4));
endmodule

bind chroma_444_upsampler chroma_444_upsampler_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .ce(ce),
  .cr_out(cr_out), .cb_out(cb_out), .out_valid(out_valid)
);

// File: tb/chroma_444_upsampler_tb_top.sv
module chroma_444_upsampler_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0;
  logic [7:0] chroma_in = '0;
  logic       chroma_is_cr = 1'b0;
  logic       cfg_offset_bin = 1'b0;
  logic       cfg_negate = 1'b0;
  logic [2:0] cfg_trim = 3'd2;
  logic [7:0] cr_out, cb_out;
  logic       out_valid;

  always #2 clk = ~clk;

  chroma_444_upsampler dut_i (
    .clk(clk), .rst(rst), .ce(ce), .chroma_in(chroma_in),
    .chroma_is_cr(chroma_is_cr), .cfg_offset_bin(cfg_offset_bin),
    .cfg_negate(cfg_negate), .cfg_trim(cfg_trim),
    .cr_out(cr_out), .cb_out(cb_out), .out_valid(out_valid)
  );

  // {cr, cb, mean_cr(prev,this), mean_cb(prev,this)}
  localparam int NP = 8;
  localparam logic [31:0] VEC [NP] = '{
    32'h0AEC_0000, 32'h14F6_0FF1, 32'h7F80_4ABB, 32'h7E81_7F81,
    32'h01FF_40C0, 32'h02FE_02FF, 32'h0000_01FF, 32'h807F_C040
  };

  int checks = 0, failures = 0, cyc = 0, start_cyc = 0, n_got = 0;
  bit started = 0, done = 0, ce_at_edge = 0;
  logic [7:0] got_cr [64], got_cb [64];
  int got_stamp [64];
  logic [7:0] last_cr = '0, last_cb = '0;
  logic [7:0] exp_cr [16], exp_cb [16];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ce_at_edge <= ce;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        checks++;
        if (!ce_at_edge) begin
          failures++;
          $display("FAIL R9 valid without ce: act=%0b exp=0", out_valid);
        end
        if (n_got < 64) begin
          got_cr[n_got] = cr_out; got_cb[n_got] = cb_out; got_stamp[n_got] = cyc;
          n_got++;
        end
      end else if (cr_out !== last_cr || cb_out !== last_cb) begin
        checks++; failures++;
        $display("FAIL R9 output moved while idle: act=%h/%h exp=%h/%h",
                 cr_out, cb_out, last_cr, last_cb);
      end
    end
    last_cr = cr_out; last_cb = cb_out;
  end

  function automatic logic [7:0] sneg(input logic [7:0] x);
    return (x == 8'h80) ? 8'h7F : 8'(-x);
  endfunction

  function automatic logic [7:0] mean_ref(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = $signed(a) + $signed(b) + 1;
    return 8'(s >>> 1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; ce = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n_got = 0; started = 0;
    check("R1 valid after reset", {31'd0, out_valid}, 0);
    check("R1 cr after reset", {24'd0, cr_out}, 0);
    check("R1 cb after reset", {24'd0, cb_out}, 0);
  endtask

  task automatic drive(input logic [7:0] v, input bit is_cr, input bit gap);
    @(negedge clk);
    chroma_in = cfg_offset_bin ? (v ^ 8'h80) : v;
    chroma_is_cr = is_cr; ce = 1'b1;
    if (!started) begin started = 1; start_cyc = cyc; end
    if (gap) begin @(negedge clk); ce = 1'b0; end
  endtask

  task automatic run(input bit ofs, input bit neg, input logic [2:0] code,
                     input bit gap, input bit lead_cb, input int npairs);
    cfg_offset_bin = ofs; cfg_negate = neg; cfg_trim = code;
    do_reset();
    if (lead_cb) begin
      drive(8'h33, 0, gap);
      started = 0;
    end
    for (int k = 0; k < npairs; k++) begin
      drive(VEC[k][31:24], 1, gap);
      drive(VEC[k][23:16], 0, gap);
    end
    for (int k = 0; k < 4; k++) begin
      drive(8'h00, 1, gap);
      drive(8'h00, 0, gap);
    end
    @(negedge clk); ce = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic build_expected(input bit neg);
    for (int k = 0; k < NP; k++) begin
      logic [7:0] cr, cb;
      cr = neg ? sneg(VEC[k][31:24]) : VEC[k][31:24];
      cb = neg ? sneg(VEC[k][23:16]) : VEC[k][23:16];
      exp_cr[2*k] = cr; exp_cb[2*k] = cb;
      if (k > 0) begin
        exp_cr[2*k-1] = neg ? mean_ref(exp_cr[2*k-2], cr) : VEC[k][15:8];
        exp_cb[2*k-1] = neg ? mean_ref(exp_cb[2*k-2], cb) : VEC[k][7:0];
      end
    end
  endtask

  task automatic check_seq(input string tag);
    check({tag, " output count"}, (n_got >= 15) ? 1 : 0, 1);
    for (int j = 0; j < 15; j++) begin
      if (j < n_got) begin
        check($sformatf("%s cr[%0d]", tag, j), {24'd0, got_cr[j]}, {24'd0, exp_cr[j]});
        check($sformatf("%s cb[%0d]", tag, j), {24'd0, got_cb[j]}, {24'd0, exp_cb[j]});
      end
    end
  endtask

  initial begin
    // R5 R6 R4: plain two's complement, centre trim
    build_expected(0);
    run(0, 0, 3'd2, 0, 0, NP);
    check_seq("R5 R6 twos");
    check("R7 first valid at centre trim", got_stamp[0] - start_cyc, 6);
    check("R10 first output is pair0 cr", {24'd0, got_cr[0]}, {24'd0, VEC[0][31:24]});

    // R2: offset binary coding gives identical results
    run(1, 0, 3'd2, 0, 0, NP);
    check_seq("R2 offset");

    // R3: negation with saturation of -128
    build_expected(1);
    run(0, 1, 3'd2, 0, 0, NP);
    check_seq("R3 negate");
    check("R3 -128 saturates", {24'd0, exp_cr[14]}, 32'h7F);

    // R9: enable gaps, R4 R10: stray leading Cb dropped
    build_expected(0);
    run(0, 0, 3'd2, 1, 0, NP);
    check_seq("R9 gapped");
    run(0, 0, 3'd1, 0, 1, NP);
    check_seq("R4 lead cb");

    // R7 R8: each trim code timed to first valid output
    for (int c = 0; c < 8; c++) begin
      int eff;
      eff = (c <= 4) ? c : 2;
      run(0, 0, 3'(c), 0, 0, 3);
      check($sformatf("%s code %0d latency", (c <= 4) ? "R7" : "R8", c),
            (n_got > 0) ? got_stamp[0] - start_cyc : -1, 4 + eff);
      check($sformatf("R10 code %0d first value", c),
            {16'd0, got_cr[0], got_cb[0]}, {16'd0, VEC[0][31:16]});
    end

    // R1: reset in the middle of a stream clears outputs
    cfg_trim = 3'd0;
    for (int k = 0; k < 3; k++) begin
      drive(VEC[k][31:24], 1, 0);
      drive(VEC[k][23:16], 0, 0);
    end
    do_reset();
    repeat (6) @(negedge clk);
    check("R1 no output after mid-stream reset", n_got, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule